// File: doc/BRIEF.md
# Serial Channel Configuration Register Bank

This block is the per-channel configuration store of a serial communications controller. It holds sixteen byte-wide write registers, a shadow copy of register 7, and four status read registers. A host interface decodes a register number and presents it together with a byte and a write strobe. Most registers take the byte as it is. Register 3 (receiver parameters) and register 14 (clock control) instead act on flags and internal state.

Two reset strobes return the channel to a known state. A hardware reset and a channel-only reset share a common set of bit masks. They differ on registers 10, 11 and 14. Register 14 bits 7:5 carry a command for the digital phase-locked loop (DPLL). The command drives its active flag, its reference source and its encoding mode (NRZI or FM). The command is not stored. The baud-rate generator enable, the hunt flag and the receiver enable leave the block as level outputs. A read port returns a status register or a write register without a clock.

Top module: `sercfg_regbank`

## Requirements
- R1: After the asynchronous reset `rst_n`, the write registers hold 0x00, except reg 4 = 0x04, reg 11 = 0x08, reg 14 = 0x20 and reg 15 = 0xF8. Status 0 reads 0x44, status 1 reads 0x06, and every output flag is 0.
- R2: A write to any register other than 3 and 14 (and 7 while redirected) stores the byte unchanged. The new value is visible on the read port after the clock edge.
- R3: Either reset strobe applies: reg1 &= 0x24, reg3 &= 0xFE, reg4 |= 0x04, reg5 &= 0x61, reg15 = 0xF8.
- R4: Either reset strobe applies: status0 = (status0 & 0x3C) | 0x44, status1 = 0x06, status3 = status10 = 0x00. It also clears the DPLL active flag, the DPLL source and the baud-rate enable, and selects NRZI (`dpll_fm` = 0).
- R5: `hw_rst` also sets reg10 = 0x00, reg11 = 0x08 and reg14 = (reg14 & 0xC0) | 0x20.
- R6: `ch_rst` alone sets reg10 &= 0x60 and reg14 = (reg14 & 0xC3) | 0x20. Reg 11 is left unchanged.
- R7: On a reg 3 write with byte v, if v[0] or v[4] is set and v[4] differs from stored bit 4, stored bit 4 and status0 bit 4 (the hunt flag) are set. Stored bit 4 is never cleared by a write. `hunt_mode` mirrors stored bit 4.
- R8: On a reg 3 write, v[0] = 1 sets the receiver enable (stored bit 0, `rx_enable`). A write never clears it. Bits 7:5 and 3:1 load from v.
- R9: Reg 14 bits 7:5 are a DPLL command: 000 none, 001 search (active=1), 010 reset missing clock, 011 disable (active=0), 100 source baud generator (`dpll_src`=0), 101 source clock pin (`dpll_src`=1), 110 FM, 111 NRZI. Codes 001, 010 and 011 clear status10 bits 7:6. A reg 14 write leaves the stored reg 14 byte unchanged.
- R10: Every reg 14 write copies bit 0 to `brg_en`.
- R11: A reg 14 write with any of bits 4:2 set raises `unsup_mode`. Only a reset clears it.
- R12: While reg15 bit 0 = 1, a reg 7 write goes to the shadow register `ext_r7` and reg 7 keeps its value. Otherwise reg 7 is written and the shadow keeps its value.
- R13: In one cycle `hw_rst` beats `ch_rst`, and either strobe beats a write. A write in a reset cycle is dropped.
- R14: `rd_sel[4]` = 1 reads write register `rd_sel[3:0]`. `rd_sel[4]` = 0 reads status 0, 1, 3 or 10, and any other status number reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_rst | input | 1 | Hardware reset strobe |
| ch_rst | input | 1 | Channel-only reset strobe |
| wr_en | input | 1 | Write strobe |
| reg_sel | input | 4 | Write register number |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 5 | Read select: bit 4 = write space, bits 3:0 = number |
| rd_data | output | 8 | Read byte (combinational) |
| ext_r7 | output | 8 | Shadow register 7 |
| dpll_active | output | 1 | DPLL in search mode |
| dpll_src | output | 1 | DPLL source: 0 baud generator, 1 clock pin |
| dpll_fm | output | 1 | DPLL encoding: 1 FM, 0 NRZI |
| brg_en | output | 1 | Baud-rate generator enable |
| hunt_mode | output | 1 | Hunt mode flag |
| rx_enable | output | 1 | Receiver enable |
| unsup_mode | output | 1 | Sticky unsupported clock-mode flag |

## Verification
The risky coincidence is a reset strobe in the same cycle as a register write. The two paths update the same registers and the same DPLL state. The bench raises `hw_rst` together with a write to reg 11, and `ch_rst` together with a reg 14 search command. It then reads back reg 11 and the DPLL and baud-rate flags. It judges them against the reset values, which must show no trace of the write.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 16;
    localparam int SEL_W    = $clog2(NUM_REGS);

    localparam logic [SEL_W-1:0] IDX_RXPAR = SEL_W'(3);
    localparam logic [SEL_W-1:0] IDX_SYNC7 = SEL_W'(7);
    localparam logic [SEL_W-1:0] IDX_CLKC  = SEL_W'(14);
    localparam logic [SEL_W-1:0] IDX_ENH   = SEL_W'(15);

    typedef enum logic [2:0] {
        DC_NULL     = 3'd0,
        DC_SEARCH   = 3'd1,
        DC_CLR_MISS = 3'd2,
        DC_OFF      = 3'd3,
        DC_SRC_BRG  = 3'd4,
        DC_SRC_PIN  = 3'd5,
        DC_FM       = 3'd6,
        DC_NRZI     = 3'd7
    } dpll_cmd_e;
endpackage

// File: rtl/sercfg_rxparam.sv
module sercfg_rxparam
    import sercfg_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] val,
    output logic [REG_W-1:0] nxt,
    output logic             hunt_hit
);
    logic [REG_W-1:0] held;

    always_comb begin
        held     = cur;
        hunt_hit = 1'b0;
        if (val[0] || val[4]) begin
            if (cur[4] != val[4]) begin
                held[4]  = 1'b1;
                hunt_hit = 1'b1;
            end
            if (val[0]) held[0] = 1'b1;
        end
        nxt = (held & 8'h11) | (val & 8'hEE);
    end
endmodule

// File: rtl/sercfg_clkctl.sv
module sercfg_clkctl
    import sercfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_rst,
    input  logic             cmd_we,
    input  logic [REG_W-1:0] cmd_val,
    output logic             dpll_active,
    output logic             dpll_src,
    output logic             dpll_fm,
    output logic             brg_en,
    output logic             unsup,
    output logic             miss_clr
);
    dpll_cmd_e cmd;
    assign cmd = dpll_cmd_e'(cmd_val[7:5]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dpll_active <= 1'b0;
            dpll_src    <= 1'b0;
            dpll_fm     <= 1'b0;
            brg_en      <= 1'b0;
            unsup       <= 1'b0;
        end else if (any_rst) begin
            dpll_active <= 1'b0;
            dpll_src    <= 1'b0;
            dpll_fm     <= 1'b0;
            brg_en      <= 1'b0;
            unsup       <= 1'b0;
        end else if (cmd_we) begin
            brg_en <= cmd_val[0];
            if (|cmd_val[4:2]) unsup <= 1'b1;
            unique case (cmd)
                DC_SEARCH:  dpll_active <= 1'b1;
                DC_OFF:     dpll_active <= 1'b0;
                DC_SRC_BRG: dpll_src    <= 1'b0;
                DC_SRC_PIN: dpll_src    <= 1'b1;
                DC_FM:      dpll_fm     <= 1'b1;
                DC_NRZI:    dpll_fm     <= 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        miss_clr = 1'b0;
        if (cmd_we) begin
            unique case (cmd)
                DC_SEARCH, DC_CLR_MISS, DC_OFF: miss_clr = 1'b1;
                default:                        miss_clr = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sercfg_regbank.sv
module sercfg_regbank
    import sercfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_rst,
    input  logic             ch_rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [SEL_W:0]   rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] ext_r7,
    output logic             dpll_active,
    output logic             dpll_src,
    output logic             dpll_fm,
    output logic             brg_en,
    output logic             hunt_mode,
    output logic             rx_enable,
    output logic             unsup_mode
);
    logic [REG_W-1:0] wreg   [NUM_REGS];
    logic [REG_W-1:0] wnext  [NUM_REGS];
    logic [REG_W-1:0] rr0, rr1, rr3, rr10;
    logic [REG_W-1:0] rr0_n, rr1_n, rr3_n, rr10_n;
    logic [REG_W-1:0] ext_n, rxpar_nxt;
    logic             any_rst, wr_ok, cmd_we, hunt_hit, miss_clr;

    assign any_rst = hw_rst | ch_rst;
    assign wr_ok   = wr_en & ~any_rst;
    assign cmd_we  = wr_ok & (reg_sel == IDX_CLKC);

    sercfg_rxparam i_rxparam (
        .cur      (wreg[IDX_RXPAR]),
        .val      (wr_data),
        .nxt      (rxpar_nxt),
        .hunt_hit (hunt_hit)
    );

    sercfg_clkctl i_clkctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_rst     (any_rst),
        .cmd_we      (cmd_we),
        .cmd_val     (wr_data),
        .dpll_active (dpll_active),
        .dpll_src    (dpll_src),
        .dpll_fm     (dpll_fm),
        .brg_en      (brg_en),
        .unsup       (unsup_mode),
        .miss_clr    (miss_clr)
    );

    always_comb begin
        wnext  = wreg;
        rr0_n  = rr0;
        rr1_n  = rr1;
        rr3_n  = rr3;
        rr10_n = rr10;
        ext_n  = ext_r7;
        if (any_rst) begin
            wnext[1]  = wreg[1] & 8'h24;
            wnext[3]  = wreg[3] & 8'hFE;
            wnext[4]  = wreg[4] | 8'h04;
            wnext[5]  = wreg[5] & 8'h61;
            wnext[15] = 8'hF8;
            rr0_n     = (rr0 & 8'h3C) | 8'h44;
            rr1_n     = 8'h06;
            rr3_n     = 8'h00;
            rr10_n    = 8'h00;
            if (hw_rst) begin
                wnext[10] = 8'h00;
                wnext[11] = 8'h08;
                wnext[14] = (wreg[14] & 8'hC0) | 8'h20;
            end else begin
                wnext[10] = wreg[10] & 8'h60;
                wnext[14] = (wreg[14] & 8'hC3) | 8'h20;
            end
        end else if (wr_ok) begin
            if (reg_sel == IDX_RXPAR) begin
                wnext[IDX_RXPAR] = rxpar_nxt;
                if (hunt_hit) rr0_n[4] = 1'b1;
            end else if (reg_sel == IDX_CLKC) begin
                if (miss_clr) rr10_n = rr10 & 8'h3F;
            end else if (reg_sel == IDX_SYNC7 && wreg[IDX_ENH][0]) begin
                ext_n = wr_data;
            end else begin
                wnext[reg_sel] = wr_data;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_wreg
            localparam logic [REG_W-1:0] RST_VAL =
                (g == 4)  ? 8'h04 :
                (g == 11) ? 8'h08 :
                (g == 14) ? 8'h20 :
                (g == 15) ? 8'hF8 : 8'h00;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) wreg[g] <= RST_VAL;
                else        wreg[g] <= wnext[g];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr0    <= 8'h44;
            rr1    <= 8'h06;
            rr3    <= 8'h00;
            rr10   <= 8'h00;
            ext_r7 <= 8'h00;
        end else begin
            rr0    <= rr0_n;
            rr1    <= rr1_n;
            rr3    <= rr3_n;
            rr10   <= rr10_n;
            ext_r7 <= ext_n;
        end
    end

    assign hunt_mode = wreg[IDX_RXPAR][4];
    assign rx_enable = wreg[IDX_RXPAR][0];

    always_comb begin
        if (rd_sel[SEL_W]) begin
            rd_data = wreg[rd_sel[SEL_W-1:0]];
        end else begin
            unique case (rd_sel[SEL_W-1:0])
                4'd0:    rd_data = rr0;
                4'd1:    rd_data = rr1;
                4'd3:    rd_data = rr3;
                4'd10:   rd_data = rr10;
                default: rd_data = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/sercfg_regbank_chk.sv
module sercfg_regbank_chk
    import sercfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             hw_rst,
    input logic             ch_rst,
    input logic             wr_en,
    input logic [SEL_W-1:0] reg_sel,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] ext_r7,
    input logic             dpll_active,
    input logic             dpll_fm,
    input logic             brg_en,
    input logic             hunt_mode,
    input logic             rx_enable,
    input logic             unsup_mode
);
    AST_RESET_CLEARS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_rst || ch_rst) |=> (!dpll_active && !dpll_fm && !brg_en && !unsup_mode)); // R4

    AST_HUNT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_mode |=> hunt_mode); // R7

    AST_RXEN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_enable) |-> $past(wr_en && !hw_rst && !ch_rst && reg_sel == 4'd3 && wr_data[0])); // R8

    AST_BRG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hw_rst && !ch_rst && reg_sel == 4'd14) |=> (brg_en == $past(wr_data[0]))); // R10

    AST_UNSUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (unsup_mode && !hw_rst && !ch_rst) |=> unsup_mode); // R11

    AST_SHADOW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext_r7) |-> $past(wr_en && !hw_rst && !ch_rst && reg_sel == 4'd7)); // R12
endmodule

bind sercfg_regbank sercfg_regbank_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_rst      (hw_rst),
    .ch_rst      (ch_rst),
    .wr_en       (wr_en),
    .reg_sel     (reg_sel),
    .wr_data     (wr_data),
    .ext_r7      (ext_r7),
    .dpll_active (dpll_active),
    .dpll_fm     (dpll_fm),
    .brg_en      (brg_en),
    .hunt_mode   (hunt_mode),
    .rx_enable   (rx_enable),
    .unsup_mode  (unsup_mode)
);

// File: tb/test_sercfg_regbank.sv
module test_sercfg_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_rst = 1'b0, ch_rst = 1'b0, wr_en = 1'b0;
    logic [3:0] reg_sel = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_sel = '0;
    logic [7:0] rd_data, ext_r7;
    logic       dpll_active, dpll_src, dpll_fm, brg_en, hunt_mode, rx_enable, unsup_mode;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    sercfg_regbank i_sercfg_regbank (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] r, input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; reg_sel = r; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input bit hw);
        @(negedge clk); hw_rst = hw; ch_rst = ~hw;
        @(negedge clk); hw_rst = 1'b0; ch_rst = 1'b0;
    endtask

    task automatic wreg(input string req, input logic [3:0] r, input logic [7:0] exp);
        rd_sel = {1'b1, r}; #1; check(req, rd_data, exp);
    endtask

    task automatic sreg(input string req, input logic [3:0] r, input logic [7:0] exp);
        rd_sel = {1'b0, r}; #1; check(req, rd_data, exp);
    endtask

    function automatic logic [7:0] flags();
        return {2'b0, unsup_mode, rx_enable, hunt_mode, brg_en, dpll_fm, dpll_active} | {7'b0, dpll_src} << 6;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        sreg("R1", 4'd0, 8'h44); sreg("R1", 4'd1, 8'h06);
        wreg("R1", 4'd4, 8'h04); wreg("R1", 4'd11, 8'h08);
        wreg("R1", 4'd14, 8'h20); wreg("R1", 4'd15, 8'hF8);
        wreg("R1", 4'd1, 8'h00);
        check("R1 flags", flags(), 8'h00);
        sreg("R14 unused status", 4'd2, 8'h00);
    endtask

    task automatic t_plain();
        wr(4'd1, 8'hFF); wr(4'd5, 8'hFF); wr(4'd10, 8'hFF); wr(4'd11, 8'h5A); wr(4'd4, 8'h00);
        wreg("R2", 4'd1, 8'hFF); wreg("R2", 4'd5, 8'hFF);
        wreg("R2", 4'd10, 8'hFF); wreg("R2", 4'd11, 8'h5A); wreg("R14 write space", 4'd4, 8'h00);
    endtask

    task automatic t_rxparam();
        wr(4'd3, 8'h10);
        wreg("R7", 4'd3, 8'h10); sreg("R7 hunt flag", 4'd0, 8'h54);
        check("R7 hunt_mode", {7'b0, hunt_mode}, 8'h01);
        wr(4'd3, 8'hE1);
        wreg("R8", 4'd3, 8'hF1); check("R8 rx_enable", {7'b0, rx_enable}, 8'h01);
        wr(4'd3, 8'h00);
        wreg("R8 sticky", 4'd3, 8'h11);
    endtask

    task automatic t_dpll();
        wr(4'd14, 8'h21);
        check("R9 search", {7'b0, dpll_active}, 8'h01); check("R10 brg on", {7'b0, brg_en}, 8'h01);
        wr(4'd14, 8'hA0);
        check("R9 pin src", {7'b0, dpll_src}, 8'h01); check("R10 brg off", {7'b0, brg_en}, 8'h00);
        wr(4'd14, 8'h80); check("R9 brg src", {7'b0, dpll_src}, 8'h00);
        wr(4'd14, 8'hC0); check("R9 fm", {7'b0, dpll_fm}, 8'h01);
        wr(4'd14, 8'hE0); check("R9 nrzi", {7'b0, dpll_fm}, 8'h00);
        wr(4'd14, 8'h40); check("R9 clr miss keeps active", {7'b0, dpll_active}, 8'h01);
        wr(4'd14, 8'h60); check("R9 disable", {7'b0, dpll_active}, 8'h00);
        sreg("R9 status10", 4'd10, 8'h00);
        wreg("R9 not stored", 4'd14, 8'h20);
        check("R11 clear", {7'b0, unsup_mode}, 8'h00);
        wr(4'd14, 8'h08); check("R11 raise", {7'b0, unsup_mode}, 8'h01);
        wr(4'd14, 8'h00); check("R11 sticky", {7'b0, unsup_mode}, 8'h01);
    endtask

    task automatic t_shadow();
        wr(4'd7, 8'h33);
        wreg("R12 direct", 4'd7, 8'h33); check("R12 shadow idle", ext_r7, 8'h00);
        wr(4'd15, 8'hF9); wr(4'd7, 8'h77);
        wreg("R12 kept", 4'd7, 8'h33); check("R12 shadow", ext_r7, 8'h77);
        wr(4'd15, 8'h00); wr(4'd7, 8'h12);
        wreg("R12 back", 4'd7, 8'h12); check("R12 shadow kept", ext_r7, 8'h77);
    endtask

    task automatic t_chrst();
        wr(4'd14, 8'hC5);
        pulse(1'b0);
        wreg("R3", 4'd1, 8'h24); wreg("R3", 4'd3, 8'h10); wreg("R3", 4'd4, 8'h04);
        wreg("R3", 4'd5, 8'h61); wreg("R3", 4'd15, 8'hF8);
        wreg("R6", 4'd10, 8'h60); wreg("R6", 4'd11, 8'h5A); wreg("R6", 4'd14, 8'h20);
        sreg("R4", 4'd0, 8'h54); sreg("R4", 4'd1, 8'h06); sreg("R4", 4'd3, 8'h00);
        check("R4 flags", flags(), 8'h08);
    endtask

    task automatic t_hwrst();
        wr(4'd10, 8'hFF); wr(4'd11, 8'h5A);
        pulse(1'b1);
        wreg("R5", 4'd10, 8'h00); wreg("R5", 4'd11, 8'h08); wreg("R5", 4'd14, 8'h20);
    endtask

    task automatic t_collide();
        @(negedge clk); hw_rst = 1'b1; wr_en = 1'b1; reg_sel = 4'd11; wr_data = 8'h77;
        @(negedge clk); hw_rst = 1'b0; wr_en = 1'b0;
        wreg("R13 hw beats write", 4'd11, 8'h08);
        @(negedge clk); ch_rst = 1'b1; wr_en = 1'b1; reg_sel = 4'd14; wr_data = 8'h21;
        @(negedge clk); ch_rst = 1'b0; wr_en = 1'b0;
        check("R13 ch beats write", {6'b0, brg_en, dpll_active}, 8'h00);
        wr(4'd10, 8'hFF);
        @(negedge clk); hw_rst = 1'b1; ch_rst = 1'b1;
        @(negedge clk); hw_rst = 1'b0; ch_rst = 1'b0;
        wreg("R13 hw beats ch", 4'd10, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset(); t_plain(); t_rxparam(); t_dpll(); t_shadow();
        t_chrst(); t_hwrst(); t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule